// File: doc/BRIEF.md
# Character Point Sequencer

This block turns one character image into the stream of single-point commands that a point-addressed, selectively erasable display needs. A requester supplies an anchor coordinate, which is the top-left point of the cell, and either a packed image of 9 columns by 14 rows or a code that picks one of four built-in test images. It then pulses `start`. The block visits every cell of the character box. Each column is walked from the anchor row downward: one lower Y per point, for 14 points. Y then returns to the anchor row and X steps right by one, until nine columns have been covered.

Every point in the box is sent, not only the lit ones. The image bit for a point selects writing (1) or erasing (0), so a character replaces whatever was drawn in that box before. Each point goes out on a valid/ready handshake to the point controller. Points whose coordinates fall off the 0..511 field are dropped silently. When the last cell has been handled, a one-cycle `done` pulse tells the requester that the block is free again.

Top module: `char_point_seq`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `done` and `pt_valid` are low until a start is accepted.
- R2: A `start` seen while idle captures `anchor_x`, `anchor_y` and the image source, and raises `busy` on the next clock edge.
- R3: Cells are visited column-major. Cell (c, r), with c in 0..8 and r in 0..13, has coordinates x = anchor_x + c and y = anchor_y − r. Inside a column r rises by one per cell, so y falls by one. After r = 13, the walk moves to r = 0 of column c + 1.
- R4: `pt_on` for cell (c, r) equals image bit c*14 + r, where bit 0 is the least significant bit of `glyph`. A value of 1 means write and 0 means erase.
- R5: Every in-range cell of the 126-cell box is offered exactly once, including cells whose image bit is 0.
- R6: While `pt_valid` is high and `pt_ready` is low, the offered point (`pt_x`, `pt_y`, `pt_on`) is held unchanged and stays valid. A point is consumed only on a clock edge with both high.
- R7: A cell with anchor_x + c > 511 or anchor_y − r < 0 is never offered. Each such cell is passed over in one clock with `pt_valid` low.
- R8: `done` is high for exactly one clock, in the cycle after the final cell (c = 8, r = 13) has been accepted or passed over. In that same cycle `busy` is low.
- R9: A `start` pulse while `busy` is high has no effect. The running character continues with its original anchor and image, and no second character follows.
- R10: With `use_rom` = 1 the image comes from built-in patterns selected by `code`: 0 lights every cell; 1 lights cells where c + r is even; 2 lights cells where c = 0, c = 8, r = 0 or r = 13; 3 lights cells where r = c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to draw one character (taken only when idle) |
| use_rom | input | 1 | 1: image from built-in patterns; 0: image from `glyph` |
| code | input | 2 | Built-in pattern selector |
| glyph | input | 126 | Packed image, bit c*14 + r for column c, row r |
| anchor_x | input | 9 | X of the top-left cell |
| anchor_y | input | 9 | Y of the top-left cell |
| busy | output | 1 | A character is in progress |
| done | output | 1 | One-cycle completion pulse |
| pt_valid | output | 1 | A point is offered |
| pt_ready | input | 1 | Point controller accepts the offered point |
| pt_x | output | 9 | X of the offered point |
| pt_y | output | 9 | Y of the offered point |
| pt_on | output | 1 | 1 = write the point, 0 = erase it |

## Verification
The hardest situation to reach is a clipped character that still has cells waiting to be passed over after its last visible point has been accepted. In that case the timing of `done` depends on how many invisible cells remain. The stimulus sweeps the anchor across the right edge (x 503..511) and the bottom rows (y 0..14), which covers every mix of clipped columns and clipped rows, including the corner where only one point is visible. For each run the bench works out the trailing skip count and from it the exact cycle of `done`. Stalls come from a pseudo-random ready pattern, and one run pulses `start` with a different anchor partway through the character.

// File: rtl/char_point_seq.sv
module char_point_seq #(
  parameter int COLS = 9,
  parameter int ROWS = 14,
  parameter int CW   = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 use_rom,
  input  logic [1:0]           code,
  input  logic [COLS*ROWS-1:0] glyph,
  input  logic [CW-1:0]        anchor_x,
  input  logic [CW-1:0]        anchor_y,
  output logic                 busy,
  output logic                 done,
  output logic                 pt_valid,
  input  logic                 pt_ready,
  output logic [CW-1:0]        pt_x,
  output logic [CW-1:0]        pt_y,
  output logic                 pt_on
);
  localparam int NB  = COLS * ROWS;
  localparam int CIW = $clog2(COLS);
  localparam int RW  = $clog2(ROWS);
  localparam logic [CIW-1:0] COL_LAST = CIW'(COLS - 1);
  localparam logic [RW-1:0]  ROW_LAST = RW'(ROWS - 1);

  function automatic logic [NB-1:0] rom_image(input logic [1:0] sel);
    logic [NB-1:0] v;
    v = '0;
    for (int c = 0; c < COLS; c++) begin
      for (int r = 0; r < ROWS; r++) begin
        case (sel)
          2'd0: v[c*ROWS+r] = 1'b1;
          2'd1: v[c*ROWS+r] = ((c + r) % 2) == 0;
          2'd2: v[c*ROWS+r] = (c == 0) || (c == COLS-1) || (r == 0) || (r == ROWS-1);
          default: v[c*ROWS+r] = (r == c);
        endcase
      end
    end
    return v;
  endfunction

  logic [CIW-1:0] col;
  logic [RW-1:0]  row;
  logic [NB-1:0]  img;
  logic [CW-1:0]  ax_q, ay_q;
  logic [CW:0]    x_sum, y_dif;
  logic           in_range, step;

  assign x_sum    = {1'b0, ax_q} + (CW+1)'(col);
  assign y_dif    = {1'b0, ay_q} - (CW+1)'(row);
  assign in_range = !x_sum[CW] && !y_dif[CW];
  assign pt_valid = busy && in_range;
  assign step     = busy && (!in_range || pt_ready);
  assign pt_x     = x_sum[CW-1:0];
  assign pt_y     = y_dif[CW-1:0];
  assign pt_on    = img[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      col  <= '0;
      row  <= '0;
      img  <= '0;
      ax_q <= '0;
      ay_q <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          col  <= '0;
          row  <= '0;
          ax_q <= anchor_x;
          ay_q <= anchor_y;
          img  <= use_rom ? rom_image(code) : glyph;
        end
      end else if (step) begin
        img <= img >> 1;
        if (row == ROW_LAST) begin
          row <= '0;
          if (col == COL_LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            col <= col + 1'b1;
          end
        end else begin
          row <= row + 1'b1;
        end
      end
    end
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && !pt_ready |=> pt_valid && $stable(pt_x) && $stable(pt_y) && $stable(pt_on));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !pt_valid);

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R1
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid |-> busy);

  // R3
  y_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pt_valid && pt_ready && pt_y != 0 && !done |=> !pt_valid || pt_y == $past(pt_y) - 1'b1 || pt_x == $past(pt_x) + 1'b1);
endmodule

// File: tb/char_point_seq_tb.sv
`timescale 1ns/1ps
module char_point_seq_tb;
  localparam int COLS = 9;
  localparam int ROWS = 14;
  localparam int NB = COLS * ROWS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic use_rom = 1'b0;
  logic [1:0] code = 2'd0;
  logic [NB-1:0] glyph = '0;
  logic [8:0] anchor_x = '0;
  logic [8:0] anchor_y = '0;
  logic pt_ready = 1'b0;
  logic busy, done, pt_valid, pt_on;
  logic [8:0] pt_x, pt_y;

  int checks = 0;
  int fails = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  char_point_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .use_rom(use_rom), .code(code),
    .glyph(glyph), .anchor_x(anchor_x), .anchor_y(anchor_y), .busy(busy),
    .done(done), .pt_valid(pt_valid), .pt_ready(pt_ready), .pt_x(pt_x),
    .pt_y(pt_y), .pt_on(pt_on)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit cell_on(input bit rom, input logic [1:0] cd,
                                 input logic [NB-1:0] g, input int c, input int r);
    if (!rom) return g[c*ROWS+r];
    case (cd)
      2'd0: return 1'b1;
      2'd1: return ((c + r) % 2) == 0;
      2'd2: return (c == 0) || (c == COLS-1) || (r == 0) || (r == ROWS-1);
      default: return r == c;
    endcase
  endfunction

  function automatic bit cell_in(input int ax, input int ay, input int k);
    return (ax + k / ROWS) <= 511 && (ay - k % ROWS) >= 0;
  endfunction

  function automatic logic [NB-1:0] make_glyph(input int seed);
    logic [NB-1:0] g;
    for (int i = 0; i < NB; i++) g[i] = ((i * seed + (seed >> 1)) % 7) < 3;
    return g;
  endfunction

  task automatic run_char(input int ax, input int ay, input bit rom, input logic [1:0] cd,
                          input logic [NB-1:0] g, input int rmode, input bit poke);
    int nxt, acc, nin, cyc, k, last;
    bit poked, rdy;
    nin = 0; last = -1;
    for (int i = 0; i < NB; i++) if (cell_in(ax, ay, i)) begin nin++; last = i; end
    k = NB - 1 - last;
    @(negedge clk);
    anchor_x = 9'(ax); anchor_y = 9'(ay); use_rom = rom; code = cd; glyph = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2
    check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    nxt = 0;
    while (nxt < NB && !cell_in(ax, ay, nxt)) nxt++;
    acc = 0; cyc = 0; poked = 0;
    while (nxt < NB && cyc < 3000) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rdy = (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : cyc[0];
      if (pt_valid) begin
        // R3 R7 coordinates
        check(int'(pt_x) == ax + nxt / ROWS, "R3 pt_x", int'(pt_x), ax + nxt / ROWS);
        check(int'(pt_y) == ay - nxt % ROWS, "R3 pt_y", int'(pt_y), ay - nxt % ROWS);
        // R4
        check(pt_on == cell_on(rom, cd, g, nxt / ROWS, nxt % ROWS), "R4 pt_on",
              int'(pt_on), int'(cell_on(rom, cd, g, nxt / ROWS, nxt % ROWS)));
        if (rdy) begin
          acc++;
          nxt++;
          while (nxt < NB && !cell_in(ax, ay, nxt)) nxt++;
        end
      end
      pt_ready = rdy;
      if (poke && !poked && acc == 20) begin
        // R9 start while busy with other anchor and image
        start = 1'b1; anchor_x = 9'(ax) ^ 9'h0F0; anchor_y = 9'(ay) ^ 9'h00F;
        glyph = ~g; use_rom = ~rom; poked = 1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    pt_ready = 1'b0;
    check(cyc < 3000, "R6 progress", cyc, 3000);
    // R5
    check(acc == nin, "R5 points offered", acc, nin);
    for (int i = 0; i < k; i++) begin
      // R7 skipped trailing cells never offered
      check(!done && !pt_valid, "R7 trailing skip", int'(done) + 2 * int'(pt_valid), 0);
      @(negedge clk);
    end
    // R8
    check(done == 1'b1 && busy == 1'b0, "R8 done timing", int'(done), 1);
    @(negedge clk);
    // R8 R9
    check(!done && !busy && !pt_valid, "R8 R9 idle after done",
          int'(done) + 2 * int'(busy) + 4 * int'(pt_valid), 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !done && !pt_valid, "R1 in reset", int'(busy) + int'(done) + int'(pt_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1
    check(!busy && !done && !pt_valid, "R1 after reset", int'(busy) + int'(done) + int'(pt_valid), 0);

    run_char(100, 200, 1'b0, 2'd0, make_glyph(5), 0, 1'b0);
    run_char(37, 300, 1'b0, 2'd0, make_glyph(11), 1, 1'b0);
    run_char(0, 13, 1'b0, 2'd0, '0, 2, 1'b0);
    run_char(505, 300, 1'b0, 2'd0, make_glyph(3), 1, 1'b0);
    run_char(50, 5, 1'b0, 2'd0, make_glyph(9), 2, 1'b0);
    run_char(511, 0, 1'b0, 2'd0, '1, 1, 1'b0);
    // R10
    for (int c = 0; c < 4; c++) run_char(200 + c, 400 - c, 1'b1, 2'(c), make_glyph(7), c % 3, 1'b0);
    // R9
    run_char(120, 250, 1'b0, 2'd0, make_glyph(13), 1, 1'b1);
    for (int x = 503; x <= 511; x++)
      for (int y = 0; y <= 14; y++)
        run_char(x, y, (x + y) % 2 == 1, 2'((x + y) % 4), make_glyph(x + y), (x * 3 + y) % 3, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule